// File: doc/BRIEF.md
# Peripheral Event Interrupt and Keyed Reset Unit

This unit sits between a peripheral core and a register bus. Seven event lines from the core each carry single-cycle pulses. Each pulse latches a sticky pending bit. A per-source mask register and a master enable combine those bits into one registered, level-sensitive interrupt line.

Software reads the pending word and writes the same value back to acknowledge what it has handled. Events that arrive in the meantime are not lost.

A separate key register lets software reset the peripheral. Only one exact key value starts a reset pulse that lasts a fixed number of cycles. While that pulse is active, the pending and mask registers are held clear. Any other value written to the key register does nothing.

The register interface is a simple single-cycle write strobe. The read path is combinational and selected by the same address.

Top module: `irq_reset_unit`

## Requirements
- R1: `irq_o` is a register. After each clock edge it equals the master enable AND the OR over all sources of (pending AND mask), using the values held before that edge.
- R2: The master enable is bit 31 of the word at offset 0x1C. A write there loads it from wdata[31]. A read there returns it in bit 31 with all other bits zero.
- R3: A pulse on evt_i[k] sets pending bit k, and the bit stays set until software clears it. The bit weights are: mode fault 0x01, slave-select fault 0x02, transmit empty 0x04, transmit underrun 0x08, receive full 0x10, receive overrun 0x20, transmit half empty 0x40.
- R4: A write to offset 0x20 clears each pending bit whose wdata bit is 1 and leaves the bits written as 0 unchanged. If an event for a bit arrives in the same cycle as the clear, the bit stays set.
- R5: The mask register is at offset 0x28, in bits 6:0. It reads back as written, and writing 0 blocks every source from the interrupt.
- R6: Writing exactly 0x0000000A to offset 0x40 drives `periph_rst_o` high from the next edge for RST_CYCLES cycles (default 4). A valid key written while the pulse is active starts the count again.
- R7: Any other value written to offset 0x40 leaves `periph_rst_o` and all register state unchanged.
- R8: While `periph_rst_o` is high, the pending and mask registers are cleared and events are ignored. The master enable keeps its value.
- R9: A read of offset 0x20 returns the latched pending bits whatever the mask holds. Offset 0x40 and any unmapped offset read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 7 | Single-cycle event pulses from the peripheral core |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte offset for both writes and reads |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Registered level interrupt |
| periph_rst_o | output | 1 | Reset pulse to the peripheral core |

## Verification
The bench aims an event and an acknowledge at the same pending bit in the same cycle. A design that lets the clear win here drops an interrupt that software has not yet seen.

It writes keys that differ from the valid one by a single bit. A decoder that compares only part of the word would then fire a spurious reset.

It lets events arrive during a reset pulse and writes a second valid key while a pulse is active. A wrong design would leave stale pending bits after the pulse or cut the pulse short.

It also sets pending bits while the mask is clear. This checks that reads still show those bits and that the interrupt stays low until both the mask and the master enable allow it.

// File: rtl/irq_rst_pkg.sv
package irq_rst_pkg;
  localparam int NSRC   = 7;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int GIE_BIT = 31;

  localparam logic [ADDR_W-1:0] OFS_GIE  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 8'h40;
  localparam logic [DATA_W-1:0] RST_KEY  = 32'h0000_000A;

  // Combined interrupt level from master enable, pending and mask.
  function automatic logic irq_level(input logic gie,
                                     input logic [NSRC-1:0] pend,
                                     input logic [NSRC-1:0] mask);
    return gie & (|(pend & mask));
  endfunction
endpackage

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_rst_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              gie_q,
  input  logic [NSRC-1:0]   pend_q,
  input  logic [NSRC-1:0]   mask_q,
  output logic              gie_we,
  output logic              gie_d,
  output logic [NSRC-1:0]   clr_mask,
  output logic              mask_we,
  output logic [NSRC-1:0]   mask_d,
  output logic              key_hit,
  output logic              key_miss,
  output logic [DATA_W-1:0] rdata_o
);
  logic key_wr;

  always_comb begin
    gie_we   = wr_en_i && (addr_i == OFS_GIE);
    gie_d    = wdata_i[GIE_BIT];
    clr_mask = (wr_en_i && (addr_i == OFS_STAT)) ? wdata_i[NSRC-1:0] : '0;
    mask_we  = wr_en_i && (addr_i == OFS_MASK);
    mask_d   = wdata_i[NSRC-1:0];
    key_wr   = wr_en_i && (addr_i == OFS_KEY);
    key_hit  = key_wr && (wdata_i == RST_KEY);
    key_miss = key_wr && (wdata_i != RST_KEY);
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_GIE:  rdata_o[GIE_BIT]  = gie_q;
      OFS_STAT: rdata_o[NSRC-1:0] = pend_q;
      OFS_MASK: rdata_o[NSRC-1:0] = mask_q;
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank
  import irq_rst_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hold,
  input  logic [NSRC-1:0] evt_i,
  input  logic [NSRC-1:0] clr_mask,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_d,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] mask_q
);
  for (genvar k = 0; k < NSRC; k++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pend_q[k] <= 1'b0;
      else if (hold)   pend_q[k] <= 1'b0;
      else if (evt_i[k]) pend_q[k] <= 1'b1;
      else if (clr_mask[k]) pend_q[k] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (hold)    mask_q <= '0;
    else if (mask_we) mask_q <= mask_d;
  end

  // R3: an event outside a reset pulse is pending on the next cycle
  assert_evt_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i && !hold) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));
  // R4: cleared bits without a colliding event are gone
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_mask & ~evt_i)) |=> ((pend_q & $past(clr_mask & ~evt_i)) == '0));
  // R8: reset pulse empties pending and mask
  assert_hold_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (pend_q == '0 && mask_q == '0));
endmodule

// File: rtl/irq_key_reset.sv
module irq_key_reset #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic key_hit,
  input  logic key_miss,
  output logic rst_active
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (key_hit)        cnt_q <= CNT_LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign rst_active = (cnt_q != '0);

  // R6: a valid key always yields an active pulse next cycle
  assert_key_starts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    key_hit |=> rst_active);
  // R7: a wrong key never starts a pulse
  assert_bad_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_miss && !rst_active) |=> !rst_active);
endmodule

// File: rtl/irq_reset_unit.sv
module irq_reset_unit
  import irq_rst_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        evt_i,
  input  logic              wr_en_i,
  input  logic [7:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              periph_rst_o
);
  logic            gie_q, gie_we, gie_d;
  logic [NSRC-1:0] pend_q, mask_q, clr_mask, mask_d;
  logic            mask_we, key_hit, key_miss, hold;
  logic            irq_next;

  irq_reg_if u_regif (
    .wr_en_i (wr_en_i), .addr_i (addr_i), .wdata_i (wdata_i),
    .gie_q (gie_q), .pend_q (pend_q), .mask_q (mask_q),
    .gie_we (gie_we), .gie_d (gie_d), .clr_mask (clr_mask),
    .mask_we (mask_we), .mask_d (mask_d),
    .key_hit (key_hit), .key_miss (key_miss), .rdata_o (rdata_o)
  );

  irq_status_bank u_bank (
    .clk (clk), .rst_n (rst_n), .hold (hold), .evt_i (evt_i),
    .clr_mask (clr_mask), .mask_we (mask_we), .mask_d (mask_d),
    .pend_q (pend_q), .mask_q (mask_q)
  );

  irq_key_reset #(.RST_CYCLES(RST_CYCLES)) u_key (
    .clk (clk), .rst_n (rst_n), .key_hit (key_hit), .key_miss (key_miss),
    .rst_active (hold)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      gie_q <= 1'b0;
    else if (gie_we) gie_q <= gie_d;
  end

  assign irq_next = irq_level(gie_q, pend_q, mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_next;
  end

  assign periph_rst_o = hold;

  // R1: interrupt follows the gated pending word one cycle later
  assert_irq_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == ($past(gie_q) & (|($past(pend_q) & $past(mask_q))))));
  // R2: master enable off means no interrupt next cycle
  assert_gie_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |=> !irq_o);
  // R5: a fully clear mask keeps the line low
  assert_mask_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !irq_o);
  // R8: master enable survives a reset pulse unless written
  assert_gie_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !gie_we) |=> $stable(gie_q));
endmodule

// File: tb/irq_reset_unit_tb.sv
module irq_reset_unit_tb;
  localparam int N = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] evt = '0;
  logic we = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic irq, prst;

  irq_reset_unit #(.RST_CYCLES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(we), .addr_i(addr),
    .wdata_i(wd), .rdata_o(rdata), .irq_o(irq), .periph_rst_o(prst));

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  logic m_gie = 0, m_irq = 0;
  logic [6:0] m_st = '0, m_en = '0;
  int m_cnt = 0;

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h1C: return {m_gie, 31'b0};
      8'h20: return {25'b0, m_st};
      8'h28: return {25'b0, m_en};
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Model update at a clock edge from the requirement text.
  task automatic model_edge();
    logic [6:0] clr;
    logic hold;
    hold  = (m_cnt != 0);
    m_irq = m_gie & (|(m_st & m_en));                       // R1
    clr   = (we && addr == 8'h20) ? wd[6:0] : 7'h0;
    if (hold) begin m_st = '0; m_en = '0; end               // R8
    else begin
      m_st = (m_st & ~clr) | evt;                           // R3 R4
      if (we && addr == 8'h28) m_en = wd[6:0];              // R5
    end
    if (we && addr == 8'h1C) m_gie = wd[31];                // R2
    if (we && addr == 8'h40 && wd == 32'hA) m_cnt = N;      // R6
    else if (m_cnt != 0) m_cnt--;
  endtask

  task automatic step(input logic [6:0] e, input logic w, input logic [7:0] a,
                      input logic [31:0] d);
    evt = e; we = w; addr = a; wd = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    evt = '0; we = 1'b0;
    chk("R1 irq", {31'b0, irq}, {31'b0, m_irq});
    chk("R6/R7 periph_rst", {31'b0, prst}, {31'b0, m_cnt != 0});
    chk("R9 read", rdata, exp_read(addr));
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    addr = 8'h20;
    chk("reset irq", {31'b0, irq}, 32'd0);
    chk("reset periph_rst", {31'b0, prst}, 32'd0);
    chk("reset status", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: pending visible while masked, R5 blocks interrupt
    step(7'h14, 0, 8'h20, 0);
    step(0, 0, 8'h20, 0);
    chk("R9 masked status", rdata, 32'h14);
    step(0, 1, 8'h1C, 32'h8000_0000);
    step(0, 0, 8'h1C, 0);
    chk("R1 masked irq", {31'b0, irq}, 32'd0);
    step(0, 1, 8'h28, 32'h10);
    step(0, 0, 8'h28, 0);
    chk("R1 irq raised", {31'b0, irq}, 32'd1);
    // R4: same-cycle set and clear on bit 4, clear bit 2
    step(7'h10, 1, 8'h20, 32'h14);
    step(0, 0, 8'h20, 0);
    chk("R4 set wins", rdata, 32'h10);
    // R5: zero mask blocks
    step(0, 1, 8'h28, 0);
    step(0, 0, 8'h28, 0);
    step(0, 0, 8'h28, 0);
    chk("R5 mask zero", {31'b0, irq}, 32'd0);
    // R7: near-miss keys
    step(0, 1, 8'h40, 32'h0B);
    step(0, 1, 8'h40, 32'h8000_000A);
    step(0, 0, 8'h20, 0);
    chk("R7 no reset", {31'b0, prst}, 32'd0);
    chk("R7 status kept", rdata, 32'h10);
    // R6/R8: valid key, events during pulse, restart
    step(0, 1, 8'h28, 32'h7F);
    step(0, 1, 8'h40, 32'h0A);
    chk("R6 pulse start", {31'b0, prst}, 32'd1);
    step(7'h7F, 0, 8'h20, 0);
    step(7'h01, 1, 8'h40, 32'h0A);
    for (int i = 0; i < N + 1; i++) step(7'h02, 0, 8'h20, 0);
    chk("R6 pulse end", {31'b0, prst}, 32'd0);
    step(0, 0, 8'h28, 0);
    chk("R8 mask cleared", rdata, 32'd0);
    step(0, 0, 8'h1C, 0);
    chk("R2 gie kept", rdata, 32'h8000_0000);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a;
      logic [31:0] d;
      logic w;
      case ($urandom % 6)
        0: a = 8'h1C; 1, 2: a = 8'h20; 3: a = 8'h28; 4: a = 8'h40; default: a = 8'h44;
      endcase
      w = ($urandom % 4) == 0;
      d = $urandom;
      if (a == 8'h40 && ($urandom % 10) == 0) d = 32'hA;
      step(7'($urandom) & 7'($urandom), w, a, d);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule